// File: doc/BRIEF.md
# Daylight Saving Time Adjuster

This block holds the daylight saving rules for a calendar clock and compares them with the running calendar. There are two rules. The spring rule asks the time counter to move one hour ahead. The autumn rule asks it to move one hour back. Each rule names a month and an hour. It also names either a fixed date or an "n-th weekday of the month" pattern. A one-bit mode selector in the rule chooses between the two patterns.

Software writes eight configuration bytes through a simple byte port at addresses 20h to 27h. A master enable bit gates both rules. The calendar counter supplies its BCD month, date, day-of-week and hour, together with a one-cycle tick at each new hour. The block answers with a one-cycle forward pulse or a one-cycle backward pulse and keeps an "adjusted" flag. Once the flag is set, the block refuses a second forward step. It is cleared by the backward step, so the repeated autumn hour cannot step back twice. A rule is honoured only after one full hour boundary has passed with the enable set.

Top module: `dst_adjuster`

## Requirements
- R1: Writes to addresses 20h..27h store the byte masked per register, and reads return it. The masks are: 20h keeps bit 7 (enable) and bits 4:0 (month); 24h keeps bits 4:0; 21h and 25h keep bits 6:0; 22h, 23h, 26h and 27h keep bits 5:0. Other addresses read 00h, and writes to them change nothing.
- R2: After synchronous reset all eight registers read 00h, and fwd_pulse, bwd_pulse and adjusted are 0.
- R3: The first hour_tick seen while the enable bit (20h bit 7) is 1 arms the block, and that tick never produces a pulse. Clearing enable disarms it.
- R4: A rule matches when its BCD month (bits 4:0) and BCD hour (bits 5:0) equal the current values. If its mode bit (day register bit 6) is 1, the week field (bits 5:3) must also equal ((date-1)/7)+1 and the day field (bits 2:0) must equal the current day-of-week. If the mode bit is 0, the date register (bits 5:0) must equal the current date.
- R5: On an hour_tick while armed and not adjusted, a forward-rule match gives fwd_pulse high for exactly the next cycle and sets adjusted. While adjusted is set, forward matches are ignored.
- R6: On an hour_tick while armed and adjusted, a reverse-rule match gives bwd_pulse high for exactly the next cycle and clears adjusted. A reverse match while not adjusted gives no pulse.
- R7: While the stored enable bit is 0, adjusted is held at 0. It is low from the second cycle after the write that clears enable.
- R8: fwd_pulse and bwd_pulse are never high together and only follow a cycle in which hour_tick was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the configuration port |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cur_month | input | 5 | Current month, BCD |
| cur_date | input | 6 | Current date, BCD |
| cur_dow | input | 3 | Current day of week |
| cur_hour | input | 6 | Current hour, BCD |
| hour_tick | input | 1 | One-cycle strobe at the start of each hour |
| fwd_pulse | output | 1 | Request to step one hour ahead |
| bwd_pulse | output | 1 | Request to step one hour back |
| adjusted | output | 1 | Summer time in effect |

## Verification
The bound checker watches several properties on every cycle: the exclusivity and single-cycle width of the two pulses, their dependence on a preceding hour tick and on the armed state, the agreement between each pulse and the adjusted flag, and the forced clearing of that flag whenever enable is low. Whether a given calendar value really matches a rule cannot be seen from those properties. The bench scenarios show it: week-of-month versus fixed-date matching, wrong hour or wrong week, the arming tick that must not fire, and the masked readback of each register.

// File: rtl/dst_pkg.sv
package dst_pkg;

    typedef struct packed {
        logic [4:0] month;
        logic       by_week;
        logic [2:0] week;
        logic [2:0] dow;
        logic [5:0] date;
        logic [5:0] hour;
    } dst_rule_t;

    typedef struct packed {
        logic [4:0] month;
        logic [5:0] date;
        logic [2:0] dow;
        logic [5:0] hour;
    } cal_now_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_SHIFTED = 2'd2
    } dst_state_e;

    // Implemented bits of each configuration byte, by offset.
    function automatic logic [7:0] cfg_mask(input int unsigned idx);
        case (idx)
            0:       return 8'h9F;
            4:       return 8'h1F;
            1, 5:    return 8'h7F;
            default: return 8'h3F;
        endcase
    endfunction

    // Week of month (1..5) from a BCD date; 0 for a zero date.
    function automatic logic [2:0] week_of_month(input logic [5:0] bcd_date);
        logic [5:0] bin;
        logic [5:0] zero_based;
        bin = ({4'd0, bcd_date[5:4]} * 6'd10) + {2'd0, bcd_date[3:0]};
        if (bin == 6'd0) return 3'd0;
        zero_based = (bin - 6'd1) / 6'd7;
        return zero_based[2:0] + 3'd1;
    endfunction

endpackage

// File: rtl/dst_regfile.sv
module dst_regfile
    import dst_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              enable,
    output dst_rule_t         fwd_rule,
    output dst_rule_t         rev_rule
);
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] LIMIT  = ADDR_W'(NUM_REGS);

    logic [7:0]        bytes_q [NUM_REGS];
    logic [ADDR_W-1:0] offset;
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign offset   = addr - BASE_A;
    assign in_range = offset < LIMIT;
    assign idx      = offset[IDX_W-1:0];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
        localparam logic [7:0] MASK = cfg_mask(i);
        always_ff @(posedge clk) begin
            if (rst)
                bytes_q[i] <= 8'h00;
            else if (we && in_range && idx == IDX_W'(i))
                bytes_q[i] <= wdata & MASK;
        end
    end

    assign rdata  = in_range ? bytes_q[idx] : 8'h00;
    assign enable = bytes_q[0][7];

    // Rule views: offset 0..3 forward, 4..7 reverse.
    for (genvar r = 0; r < 2; r++) begin : g_rule
        dst_rule_t rule;
        assign rule.month   = bytes_q[4*r][4:0];
        assign rule.by_week = bytes_q[4*r+1][6];
        assign rule.week    = bytes_q[4*r+1][5:3];
        assign rule.dow     = bytes_q[4*r+1][2:0];
        assign rule.date    = bytes_q[4*r+2][5:0];
        assign rule.hour    = bytes_q[4*r+3][5:0];
    end
    assign fwd_rule = g_rule[0].rule;
    assign rev_rule = g_rule[1].rule;

endmodule

// File: rtl/dst_rule_match.sv
module dst_rule_match
    import dst_pkg::*;
(
    input  dst_rule_t rule,
    input  cal_now_t  now,
    output logic      hit
);
    logic       month_eq;
    logic       hour_eq;
    logic       day_eq;
    logic [2:0] cur_week;

    assign cur_week = week_of_month(now.date);
    assign month_eq = rule.month == now.month;
    assign hour_eq  = rule.hour == now.hour;

    always_comb begin
        if (rule.by_week)
            day_eq = (rule.week == cur_week) && (rule.dow == now.dow);
        else
            day_eq = rule.date == now.date;
    end

    assign hit = month_eq && hour_eq && day_eq;

endmodule

// File: rtl/dst_ctrl.sv
module dst_ctrl
    import dst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic hour_tick,
    input  logic fwd_hit,
    input  logic rev_hit,
    output logic fwd_pulse,
    output logic bwd_pulse,
    output logic adjusted,
    output logic armed
);
    dst_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            fwd_pulse <= 1'b0;
            bwd_pulse <= 1'b0;
        end else begin
            fwd_pulse <= 1'b0;
            bwd_pulse <= 1'b0;
            if (!enable) begin
                state_q <= ST_IDLE;
            end else if (hour_tick) begin
                case (state_q)
                    ST_IDLE: state_q <= ST_ARMED;
                    ST_ARMED: if (fwd_hit) begin
                        state_q   <= ST_SHIFTED;
                        fwd_pulse <= 1'b1;
                    end
                    ST_SHIFTED: if (rev_hit) begin
                        state_q   <= ST_ARMED;
                        bwd_pulse <= 1'b1;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign adjusted = state_q == ST_SHIFTED;
    assign armed    = state_q != ST_IDLE;

endmodule

// File: rtl/dst_adjuster.sv
module dst_adjuster
    import dst_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [4:0]        cur_month,
    input  logic [5:0]        cur_date,
    input  logic [2:0]        cur_dow,
    input  logic [5:0]        cur_hour,
    input  logic              hour_tick,
    output logic              fwd_pulse,
    output logic              bwd_pulse,
    output logic              adjusted
);
    dst_rule_t fwd_rule;
    dst_rule_t rev_rule;
    cal_now_t  now;
    logic      cfg_enable;
    logic      fwd_hit;
    logic      rev_hit;
    logic      rule_armed;

    assign now.month = cur_month;
    assign now.date  = cur_date;
    assign now.dow   = cur_dow;
    assign now.hour  = cur_hour;

    dst_regfile #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .enable   (cfg_enable),
        .fwd_rule (fwd_rule),
        .rev_rule (rev_rule)
    );

    dst_rule_match fwd_match_i (.rule(fwd_rule), .now(now), .hit(fwd_hit));
    dst_rule_match rev_match_i (.rule(rev_rule), .now(now), .hit(rev_hit));

    dst_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .enable    (cfg_enable),
        .hour_tick (hour_tick),
        .fwd_hit   (fwd_hit),
        .rev_hit   (rev_hit),
        .fwd_pulse (fwd_pulse),
        .bwd_pulse (bwd_pulse),
        .adjusted  (adjusted),
        .armed     (rule_armed)
    );

endmodule

// File: rtl/dst_adjuster_checker.sv
module dst_adjuster_checker (
    input logic clk,
    input logic rst,
    input logic hour_tick,
    input logic fwd_pulse,
    input logic bwd_pulse,
    input logic adjusted,
    input logic enable,
    input logic armed
);
    assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(fwd_pulse && bwd_pulse));

    assert_pulse_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
        (fwd_pulse || bwd_pulse) |-> $past(hour_tick));

    assert_fwd_single_R5: assert property (@(posedge clk) disable iff (rst)
        fwd_pulse |=> !fwd_pulse);

    assert_fwd_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        fwd_pulse |-> adjusted);

    assert_bwd_single_R6: assert property (@(posedge clk) disable iff (rst)
        bwd_pulse |=> !bwd_pulse);

    assert_bwd_clears_flag_R6: assert property (@(posedge clk) disable iff (rst)
        bwd_pulse |-> !adjusted);

    assert_pulse_needs_arm_R3: assert property (@(posedge clk) disable iff (rst)
        (fwd_pulse || bwd_pulse) |-> $past(armed));

    assert_disable_disarms_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> !armed);

    assert_disable_clears_flag_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> !adjusted);

endmodule

bind dst_adjuster dst_adjuster_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .hour_tick (hour_tick),
    .fwd_pulse (fwd_pulse),
    .bwd_pulse (bwd_pulse),
    .adjusted  (adjusted),
    .enable    (cfg_enable),
    .armed     (rule_armed)
);

// File: tb/dst_adjuster_tb.sv
module dst_adjuster_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [4:0] cur_month = 5'h01;
    logic [5:0] cur_date = 6'h01;
    logic [2:0] cur_dow = 3'd0;
    logic [5:0] cur_hour = 6'h00;
    logic       hour_tick = 1'b0;
    logic       fwd_pulse, bwd_pulse, adjusted;

    int tests = 0;
    int fails = 0;
    int fcnt = 0;
    int bcnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dst_adjuster dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_month(cur_month),
        .cur_date(cur_date), .cur_dow(cur_dow), .cur_hour(cur_hour),
        .hour_tick(hour_tick), .fwd_pulse(fwd_pulse), .bwd_pulse(bwd_pulse),
        .adjusted(adjusted)
    );

    // ---------------- behavioural reference model ----------------
    byte unsigned m_cfg [8];
    bit m_armed, m_adj, m_fwd, m_bwd;

    function automatic int bcd(input int v);
        return (v / 16) * 10 + (v % 16);
    endfunction

    function automatic byte unsigned mask_of(input int i);
        if (i == 0) return 8'h9F;
        if (i == 4) return 8'h1F;
        if (i == 1 || i == 5) return 8'h7F;
        return 8'h3F;
    endfunction

    function automatic bit rule_hit(input int b);
        int d;
        if (bcd(m_cfg[b] & 8'h1F) != bcd(cur_month)) return 0;
        if (bcd(m_cfg[b+3]) != bcd(cur_hour)) return 0;
        d = bcd(cur_date);
        if (m_cfg[b+1][6])
            return (((m_cfg[b+1] >> 3) & 7) == ((d - 1) / 7 + 1)) &&
                   ((m_cfg[b+1] & 7) == cur_dow);
        return bcd(m_cfg[b+2]) == d;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_cfg[i]) m_cfg[i] = 0;
            m_armed = 0; m_adj = 0; m_fwd = 0; m_bwd = 0;
        end else begin
            m_fwd = 0; m_bwd = 0;
            if (!m_cfg[0][7]) begin
                m_armed = 0; m_adj = 0;
            end else if (hour_tick) begin
                if (m_armed) begin
                    if (m_adj && rule_hit(4)) begin m_bwd = 1; m_adj = 0; end
                    else if (!m_adj && rule_hit(0)) begin m_fwd = 1; m_adj = 1; end
                end
                m_armed = 1;
            end
            if (reg_we && reg_addr >= 8'h20 && reg_addr <= 8'h27)
                m_cfg[reg_addr - 8'h20] = reg_wdata & mask_of(reg_addr - 8'h20);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R5 fwd_pulse", fwd_pulse, m_fwd);
            check("R6 bwd_pulse", bwd_pulse, m_bwd);
            check("R7 adjusted", adjusted, m_adj);
            check("R8 exclusive", fwd_pulse & bwd_pulse, 0);
            check("R1 rdata", reg_rdata,
                  (reg_addr >= 8'h20 && reg_addr <= 8'h27) ? m_cfg[reg_addr - 8'h20] : 0);
            if (fwd_pulse) fcnt++;
            if (bwd_pulse) bcnt++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 0;
    endtask

    task automatic tick(input logic [4:0] mo, input logic [5:0] da,
                        input logic [2:0] dw, input logic [5:0] hr);
        @(posedge clk); #1;
        cur_month = mo; cur_date = da; cur_dow = dw; cur_hour = hr; hour_tick = 1;
        @(posedge clk); #1;
        hour_tick = 0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R2: reset state
        reg_addr = 8'h20; #1;
        check("R2 rdata", reg_rdata, 0);
        check("R2 outputs", {fwd_pulse, bwd_pulse, adjusted}, 0);

        // R1: masked readback and out-of-range behaviour
        for (int a = 8'h1F; a <= 8'h28; a++) wr(a[7:0], 8'hFF);
        for (int a = 8'h1F; a <= 8'h28; a++) begin
            @(negedge clk); reg_addr = a[7:0]; #1;
            check("R1 readback", reg_rdata,
                  (a >= 8'h20 && a <= 8'h27) ? mask_of(a - 8'h20) : 0);
        end
        for (int a = 8'h20; a <= 8'h27; a++) wr(a[7:0], 8'h00);

        // Rules: fwd 2nd Sunday of March 02h; rev 1st Sunday of Nov 02h
        wr(8'h21, 8'h50); wr(8'h23, 8'h02);
        wr(8'h24, 8'h11); wr(8'h25, 8'h48); wr(8'h27, 8'h02);
        wr(8'h20, 8'h83);

        fcnt = 0; bcnt = 0;
        tick(5'h03, 6'h10, 3'd0, 6'h02);
        check("R3 arming tick gives no pulse", fcnt, 0);
        tick(5'h03, 6'h03, 3'd0, 6'h02);
        check("R4 wrong week", fcnt, 0);
        tick(5'h03, 6'h10, 3'd0, 6'h03);
        check("R4 wrong hour", fcnt, 0);
        tick(5'h03, 6'h10, 3'd0, 6'h02);
        check("R5 forward step", fcnt, 1);
        check("R5 adjusted set", adjusted, 1);
        tick(5'h03, 6'h10, 3'd0, 6'h02);
        check("R5 no second forward", fcnt, 1);

        tick(5'h11, 6'h05, 3'd0, 6'h02);
        check("R6 backward step", bcnt, 1);
        check("R6 adjusted cleared", adjusted, 0);
        tick(5'h11, 6'h05, 3'd0, 6'h02);
        check("R6 repeated hour ignored", bcnt, 1);

        // Fixed-date mode: 25 March 14h
        wr(8'h21, 8'h00); wr(8'h22, 8'h25); wr(8'h23, 8'h14);
        tick(5'h03, 6'h25, 3'd3, 6'h14);
        check("R4 date mode match", fcnt, 2);

        // Disable clears flag
        wr(8'h20, 8'h03);
        @(posedge clk); #1;
        @(negedge clk);
        check("R7 disable clears adjusted", adjusted, 0);
        wr(8'h20, 8'h83);
        tick(5'h03, 6'h25, 3'd3, 6'h14);
        check("R3 re-arm tick gives no pulse", fcnt, 2);

        // No tick, matching time: no pulse
        @(posedge clk); #1;
        cur_month = 5'h03; cur_date = 6'h25; cur_dow = 3'd3; cur_hour = 6'h14;
        repeat (6) @(posedge clk);
        #1;
        check("R8 no pulse without tick", fcnt, 2);
        tick(5'h03, 6'h25, 3'd3, 6'h14);
        check("R5 forward after re-arm", fcnt, 3);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule